// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead-Band

This block is one PWM channel built around a symmetric up-down time base. The counter climbs from zero to the period value and falls back to zero, so one PWM period takes twice the period value in clock cycles. The counter is compared with compare A. Matching on the way up raises a reference waveform, and matching on the way down drops it. The result is a pulse centred on the top of the triangle.

A dead-band stage turns the reference into a complementary pair for a half-bridge. The high-side output is the reference with its rising edges delayed by a programmable count. The low-side output is the inverted reference with its own rising edges delayed by a second count. The two outputs therefore can never be high together.

Period and compare values are written into shadow copies through a simple write port. They move into the active copies only when the counter sits at zero, so a period that is already running is never torn. Each zero event can raise a pending interrupt flag and emit a one-cycle start-of-conversion strobe for an ADC. Each of these has its own prescaler. A common time-base enable holds the counter at zero, so several channels can start together.

Top module: `cpwm_deadband`

## Requirements
- R1: While `tb_en` is high, `count` starts at 0 in the first enabled cycle and then rises by one per cycle up to the active period P. It then falls by one per cycle to 0 and repeats, giving a full cycle of 2*P clocks.
- R2: A period written to the shadow (address 0) becomes active only in a cycle where `count` is 0. The running triangle still peaks at the old period, and the new period governs from the next zero onward.
- R3: Compare A (address 1) and compare B (address 2) are shadowed the same way. The active values reload only in a cycle where `count` is 0.
- R4: The reference goes high the cycle after `count` equals compare A while rising, and low the cycle after it equals compare A while falling. At the peak, a match counts once, as a rising match. With zero dead time, `out_hi` equals the reference delayed by one further cycle: for compare C it is high from enabled cycle C+2 through 2P-C+1.
- R5: The rising edge of `out_hi` is delayed by the rising delay (address 3) in cycles beyond the zero-delay case. The rising edge of `out_lo` is delayed by the falling delay (address 4) beyond the cycle after the reference falls. Falling edges of both outputs are not delayed.
- R6: `out_hi` and `out_lo` are never high in the same cycle.
- R7: When a delay exceeds the width of the pulse it applies to, that output stays low for the whole pulse, with no glitch.
- R8: The control register (address 5) field bits [1:0] selects the interrupt prescale N (0 = off, 1 to 3 = every Nth zero event). When the prescale fires, `irq` rises the next cycle. It stays high until `irq_clr` is seen in a cycle with no new firing. A firing wins over a clear in the same cycle.
- R9: Control bits [3:2] select the start-of-conversion prescale in the same way. Each firing gives `soc` high for exactly one cycle, the cycle after the zero event. A value of 0 gives no strobes.
- R10: While `tb_en` is low, `count` is held at 0 from the next cycle. The reference is forced low, and both prescale counters restart, so re-enabling starts a fresh, aligned period.
- R11: `cmpb_hit` pulses for one cycle the cycle after `count` equals active compare B while enabled. That is twice per period for a value strictly between 0 and P, and once when it equals P.
- R12: Reset values:
  - `count`, `out_hi`, `out_lo`, `irq`, `soc` and `cmpb_hit` are 0 during reset.
  - Registers reset to period 50002, both compares 1000, both delays 100, and both prescales 1.
  - With these defaults, `out_hi` first rises in enabled cycle 1102.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Time-base enable; low holds the counter at zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 compare A, 2 compare B, 3 rising delay, 4 falling delay, 5 control) |
| wr_data | input | CNT_W | Register write data |
| irq_clr | input | 1 | Clears the pending interrupt flag |
| count | output | CNT_W | Time-base counter value |
| out_hi | output | 1 | High-side output (rising-edge delayed reference) |
| out_lo | output | 1 | Low-side output (inverted, rising-edge delayed reference) |
| cmpb_hit | output | 1 | One-cycle compare B match strobe |
| irq | output | 1 | Pending interrupt flag |
| soc | output | 1 | One-cycle ADC start-of-conversion strobe |

## Verification
The hardest situation to reach is a shadow update landing mid-period. The bench has to show that the old value keeps governing until the counter next reaches zero, and that the switch lands on exactly the right cycle. The stimulus writes a new period, and in a separate scenario a new compare A, at a known cycle inside an enabled run. It then compares the whole counter trace, or the per-period high counts, before and after the following zero against values computed from the triangle formula. The dead-band corner where the delay exceeds the pulse is reached by programming delays longer than the reference high and low widths. The bench then confirms that both outputs stay low for an entire steady-state period.

// File: rtl/cpwm_deadband.sv
`timescale 1ns/1ps
module cpwm_deadband #(
  parameter int CNT_W   = 16,
  parameter int DB_W    = 10,
  parameter int PS_W    = 2,
  parameter int PRD_RST = 50002,
  parameter int CMP_RST = 1000,
  parameter int DB_RST  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             out_hi,
  output logic             out_lo,
  output logic             cmpb_hit,
  output logic             irq,
  output logic             soc
);

  localparam logic [2:0] A_PRD = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2,
                         A_RED = 3'd3, A_FED  = 3'd4, A_CTL  = 3'd5;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO   = '0;
  localparam logic [DB_W-1:0]  DB_MAX = '1;
  localparam logic [DB_W-1:0]  DB_ONE = DB_W'(1);
  localparam logic [PS_W-1:0]  PS_ONE = PS_W'(1);

  logic [CNT_W-1:0] prd_sh, prd_act, cmpa_sh, cmpa_act, cmpb_sh, cmpb_act;
  logic [DB_W-1:0]  red_q, fed_q, hcnt, lcnt;
  logic [PS_W-1:0]  irq_ps, soc_ps, irq_div, soc_div;
  logic             up, ref_q;

  // register write port (shadows, delays, control)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_sh  <= CNT_W'(PRD_RST);
      cmpa_sh <= CNT_W'(CMP_RST);
      cmpb_sh <= CNT_W'(CMP_RST);
      red_q   <= DB_W'(DB_RST);
      fed_q   <= DB_W'(DB_RST);
      irq_ps  <= PS_ONE;
      soc_ps  <= PS_ONE;
    end else if (wr_en) begin
      case (wr_addr)
        A_PRD:  prd_sh  <= wr_data;
        A_CMPA: cmpa_sh <= wr_data;
        A_CMPB: cmpb_sh <= wr_data;
        A_RED:  red_q   <= wr_data[DB_W-1:0];
        A_FED:  fed_q   <= wr_data[DB_W-1:0];
        A_CTL: begin
          irq_ps <= wr_data[PS_W-1:0];
          soc_ps <= wr_data[2*PS_W-1:PS_W];
        end
        default: ;
      endcase
    end
  end

  wire at_zero  = (count == ZERO);
  wire at_top   = (count == prd_act);
  wire zero_evt = tb_en && at_zero;

  // active copies reload whenever the counter rests at zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act  <= CNT_W'(PRD_RST);
      cmpa_act <= CNT_W'(CMP_RST);
      cmpb_act <= CNT_W'(CMP_RST);
    end else if (at_zero) begin
      prd_act  <= prd_sh;
      cmpa_act <= cmpa_sh;
      cmpb_act <= cmpb_sh;
    end
  end

  // up-down time base; 'up' records the direction of arrival at count
  always_ff @(posedge clk) begin
    if (!rst_n || !tb_en || prd_act == ZERO) begin
      count <= ZERO;
      up    <= 1'b1;
    end else if (up) begin
      if (at_top) begin
        count <= count - ONE;
        up    <= 1'b0;
      end else begin
        count <= count + ONE;
      end
    end else begin
      if (at_zero) begin
        count <= count + ONE;
        up    <= 1'b1;
      end else begin
        count <= count - ONE;
      end
    end
  end

  // action logic: set on rising match, clear on falling match
  always_ff @(posedge clk) begin
    if (!rst_n || !tb_en)                  ref_q <= 1'b0;
    else if (count == cmpa_act)            ref_q <= up;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmpb_hit <= 1'b0;
    else        cmpb_hit <= tb_en && (count == cmpb_act);
  end

  // dead-band: run-length counters on the reference and its inverse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '0;
      lcnt   <= '0;
      out_hi <= 1'b0;
      out_lo <= 1'b0;
    end else begin
      hcnt   <= !ref_q ? '0 : (hcnt == DB_MAX ? hcnt : hcnt + DB_ONE);
      lcnt   <=  ref_q ? '0 : (lcnt == DB_MAX ? lcnt : lcnt + DB_ONE);
      out_hi <=  ref_q && (hcnt >= red_q);
      out_lo <= !ref_q && (lcnt >= fed_q);
    end
  end

  // event triggers with prescale
  wire irq_fire = zero_evt && (irq_ps != '0) && (irq_div + PS_ONE == irq_ps);
  wire soc_fire = zero_evt && (soc_ps != '0) && (soc_div + PS_ONE == soc_ps);

  always_ff @(posedge clk) begin
    if (!rst_n || !tb_en) begin
      irq_div <= '0;
      soc_div <= '0;
    end else if (zero_evt) begin
      if (irq_ps != '0) irq_div <= irq_fire ? '0 : irq_div + PS_ONE;
      if (soc_ps != '0) soc_div <= soc_fire ? '0 : soc_div + PS_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      soc <= 1'b0;
    end else begin
      soc <= soc_fire;
      if (irq_fire)     irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tb_en |=> (count == ZERO) || (count == $past(count) + ONE) || (count == $past(count) - ONE));
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= prd_act);
  assert_hi_needs_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_hi |-> $past(ref_q));
  assert_lo_needs_noref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_lo |-> !$past(ref_q));
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi && out_lo));
  assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  assert_soc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soc && count != ZERO |=> !soc);
  assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> count == ZERO);

endmodule

// File: tb/cpwm_deadband_test.sv
`timescale 1ns/1ps
module cpwm_deadband_test;
  logic clk = 0, rst_n = 0, tb_en = 0, wr_en = 0, irq_clr = 0;
  logic [2:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count;
  logic out_hi, out_lo, cmpb_hit, irq, soc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpwm_deadband uut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_clr(irq_clr), .count(count), .out_hi(out_hi),
    .out_lo(out_lo), .cmpb_hit(cmpb_hit), .irq(irq), .soc(soc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tri_wave(input int p, input int j);
    int m = j % (2 * p);
    return (m <= p) ? m : 2 * p - m;
  endfunction

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  // leaves the bench at a negedge with tb_en just raised: enabled cycle 0
  task automatic setup(input int p, input int ca, input int cb, input int red,
                       input int fed, input int ctl);
    @(negedge clk); tb_en = 0;
    wr(0, p); wr(1, ca); wr(2, cb); wr(3, red); wr(4, fed); wr(5, ctl);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    repeat (20) @(negedge clk);
    tb_en = 1;
  endtask

  task automatic t_reset_defaults();
    int hi_at_1101 = 0, hi_at_1102 = 0, lo_at_1002 = 1;
    repeat (3) @(negedge clk);
    chk(count == 0 && !out_hi && !out_lo && !irq && !soc && !cmpb_hit,
        "R12 reset outputs", {count, 3'b0} | out_hi | out_lo | irq | soc, 0);
    rst_n = 1;
    repeat (120) @(negedge clk);
    chk(out_lo == 1, "R12 out_lo idle high after reset", out_lo, 1);
    tb_en = 1;
    for (int k = 0; k < 1103; k++) begin
      if (k == 1101) hi_at_1101 = out_hi;
      if (k == 1102) hi_at_1102 = out_hi;
      if (k == 1002) lo_at_1002 = out_lo;
      @(negedge clk);
    end
    chk(hi_at_1101 == 0 && hi_at_1102 == 1, "R12 default out_hi edge at 1102",
        hi_at_1101 * 10 + hi_at_1102, 1);
    chk(lo_at_1002 == 0, "R12 default out_lo low at 1002", lo_at_1002, 0);
  endtask

  task automatic t_triangle_period();
    int bad1 = 0, bad2 = 0, a1 = 0, e1 = 0, a2 = 0, e2 = 0;
    setup(20, 5, 5, 0, 0, 5);
    for (int k = 0; k <= 80; k++) begin
      int e = (k <= 40) ? tri_wave(20, k) : tri_wave(12, k - 40);
      if (count != 16'(e)) begin
        if (k <= 40) begin if (bad1 == 0) begin a1 = count; e1 = e; end bad1++; end
        else         begin if (bad2 == 0) begin a2 = count; e2 = e; end bad2++; end
      end
      if (k == 10) begin wr_en = 1; wr_addr = 0; wr_data = 16'd12; end
      if (k == 11) wr_en = 0;
      @(negedge clk);
    end
    chk(bad1 == 0, "R1 triangle sequence", a1, e1);
    chk(bad2 == 0, "R2 period shadow switch at zero", a2, e2);
  endtask

  task automatic t_compare_shadow();
    int a_w1 = 0, a_w2 = 0, b_w2 = 0, a6 = 0, a7 = 0;
    setup(20, 5, 5, 0, 0, 5);
    for (int k = 0; k < 80; k++) begin
      if (k == 6) a6 = out_hi;
      if (k == 7) a7 = out_hi;
      if (k < 40) a_w1 += out_hi; else begin a_w2 += out_hi; b_w2 += out_lo; end
      if (k == 20) begin wr_en = 1; wr_addr = 1; wr_data = 16'd8; end
      if (k == 21) wr_en = 0;
      @(negedge clk);
    end
    chk(a6 == 0 && a7 == 1, "R4 out_hi first high at C+2", a6 * 10 + a7, 1);
    chk(a_w1 == 30, "R3 old compare governs current period", a_w1, 30);
    chk(a_w2 == 24, "R3 new compare after zero", a_w2, 24);
    chk(b_w2 == 16, "R4 out_lo complements with zero delay", b_w2, 16);
  endtask

  task automatic t_deadband();
    int a_w = 0, b_w = 0, both = 0, a9 = 0, a10 = 0, b40 = 0, b41 = 0;
    setup(20, 5, 5, 3, 4, 5);
    for (int k = 0; k < 80; k++) begin
      if (k == 9) a9 = out_hi;
      if (k == 10) a10 = out_hi;
      if (k == 40) b40 = out_lo;
      if (k == 41) b41 = out_lo;
      if (out_hi && out_lo) both++;
      if (k >= 40) begin a_w += out_hi; b_w += out_lo; end
      @(negedge clk);
    end
    chk(a9 == 0 && a10 == 1, "R5 out_hi rise delayed by 3", a9 * 10 + a10, 1);
    chk(b40 == 0 && b41 == 1, "R5 out_lo rise delayed by 4", b40 * 10 + b41, 1);
    chk(a_w == 27, "R5 out_hi width", a_w, 27);
    chk(b_w == 6, "R5 out_lo width", b_w, 6);
    chk(both == 0, "R6 outputs never both high", both, 0);
  endtask

  task automatic t_long_dead();
    int a_w = 0, b_w = 0, both = 0;
    setup(20, 5, 5, 40, 12, 5);
    for (int k = 0; k < 80; k++) begin
      if (out_hi && out_lo) both++;
      if (k >= 40) begin a_w += out_hi; b_w += out_lo; end
      @(negedge clk);
    end
    chk(a_w == 0, "R7 out_hi suppressed when delay exceeds pulse", a_w, 0);
    chk(b_w == 0, "R7 out_lo suppressed when delay exceeds gap", b_w, 0);
    chk(both == 0, "R6 no overlap with long delays", both, 0);
  endtask

  task automatic t_irq_soc();
    int i0 = 1, i1 = 0, i6 = 1, i40 = 1, i41 = 0, s1 = 0, s2 = 1, s_cnt = 0;
    setup(20, 5, 5, 0, 0, 5);
    for (int k = 0; k < 80; k++) begin
      case (k)
        0: i0 = irq;  1: begin i1 = irq; s1 = soc; end  2: s2 = soc;
        6: i6 = irq;  40: i40 = irq;  41: i41 = irq;
        default: ;
      endcase
      s_cnt += soc;
      irq_clr = (k == 5);
      @(negedge clk);
    end
    irq_clr = 0;
    chk(i0 == 0 && i1 == 1, "R8 irq set after zero event", i0 * 10 + i1, 1);
    chk(i6 == 0, "R8 irq cleared by irq_clr", i6, 0);
    chk(i40 == 0 && i41 == 1, "R8 irq set again at next zero", i40 * 10 + i41, 1);
    chk(s1 == 1 && s2 == 0, "R9 soc single-cycle pulse", s1 * 10 + s2, 10);
    chk(s_cnt == 2, "R9 soc once per period", s_cnt, 2);
  endtask

  task automatic t_prescale();
    int i_cnt = 0, s_cnt = 0;
    setup(20, 5, 5, 0, 0, 3 | (2 << 2));
    for (int k = 0; k < 240; k++) begin
      i_cnt += irq;
      s_cnt += soc;
      irq_clr = irq;
      @(negedge clk);
    end
    irq_clr = 0;
    chk(i_cnt == 2, "R8 irq prescale 3 over 6 zero events", i_cnt, 2);
    chk(s_cnt == 3, "R9 soc prescale 2 over 6 zero events", s_cnt, 3);
    setup(20, 5, 5, 0, 0, 1);
    s_cnt = 0;
    for (int k = 0; k < 80; k++) begin s_cnt += soc; @(negedge clk); end
    chk(s_cnt == 0, "R9 soc prescale 0 disables strobes", s_cnt, 0);
  endtask

  task automatic t_cmpb();
    int c_mid = 0, c_top = 0, h5 = 0, h6 = 0;
    setup(20, 5, 5, 0, 0, 5);
    for (int k = 0; k < 40; k++) begin
      if (k == 5) h5 = cmpb_hit;
      if (k == 6) h6 = cmpb_hit;
      c_mid += cmpb_hit;
      @(negedge clk);
    end
    setup(20, 5, 20, 0, 0, 5);
    for (int k = 0; k < 40; k++) begin c_top += cmpb_hit; @(negedge clk); end
    chk(h5 == 0 && h6 == 1, "R11 cmpb_hit one cycle after match", h5 * 10 + h6, 1);
    chk(c_mid == 2, "R11 two compare B hits per period", c_mid, 2);
    chk(c_top == 1, "R11 single hit at the peak", c_top, 1);
  endtask

  task automatic t_hold();
    int bad = 0, s_seen = 0;
    setup(20, 5, 5, 0, 0, 5);
    repeat (15) @(negedge clk);
    tb_en = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (count != 0) bad++;
      s_seen += soc;
    end
    chk(bad == 0, "R10 counter held at zero while disabled", bad, 0);
    chk(out_hi == 0, "R10 reference forced low while disabled", out_hi, 0);
    chk(s_seen == 0, "R10 no zero events while disabled", s_seen, 0);
  endtask

  initial begin
    t_reset_defaults();
    t_triangle_period();
    t_compare_shadow();
    t_deadband();
    t_long_dead();
    t_irq_soc();
    t_prescale();
    t_cmpb();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule